// File: doc/BRIEF.md
# Three-Bank Selectable Clock Divider

The block takes one fast core clock, chosen between an oscillator input and a reference input, and derives three banks of divided clocks from it. Bank A drives five identical outputs, bank B four and bank C two. A shared halving stage can double every bank's ratio. Each bank then picks one of two ratios with its own select bit. A further output carries the bank A clock back to an external phase comparator as the feedback clock.

All three banks are derived from one common frame counter. Their edges therefore stay aligned: every bank rises on the same core edge at the start of each frame. Ratio changes are held back until the frame boundary, so no output ever shows a shortened pulse. One active-high input does two jobs. It resets all divider state and it releases every bank output to high impedance. Its release is synchronised to the core clock before the dividers start.

Top module: `tribank_clkdiv`

## Requirements
- R1: While `mr_oe` is high, all eleven bank outputs are released to high impedance at once (no clock edge needed) and `fb_o` is driven low; all divider state is cleared.
- R2: All outputs within one bank carry the same value at every instant.
- R3: Bank A divides its input by 4 when `sel_a` is 0 and by 6 when `sel_a` is 1.
- R4: Bank B divides its input by 4 when `sel_b` is 0 and by 2 when `sel_b` is 1.
- R5: Bank C divides its input by 2 when `sel_c` is 0 and by 4 when `sel_c` is 1.
- R6: With `pre_sel` at 0 the banks are fed the core clock unchanged; with `pre_sel` at 1 they are fed the core clock halved, so every ratio doubles (total divisors 2, 4, 6, 8 or 12 core cycles).
- R7: Each output is high for exactly half its period and low for the other half, counted in core clock cycles, for every ratio including 6 and 12.
- R8: After `mr_oe` falls, every bank output and `fb_o` rise together on the fourth rising core clock edge, and every bank then rises on each core edge that is a whole multiple of its period after that first edge.
- R9: The select inputs (`pre_sel`, `sel_a`, `sel_b`, `sel_c`) are sampled only on the core edge that closes each 24-cycle frame, and also continuously before the dividers start. A new setting first affects the waveform at the start of the next frame, with no runt pulse.
- R10: With `bypass_sel` at 1 the dividers run from `ref_clk`; with `bypass_sel` at 0 they run from `osc_clk`.
- R11: `fb_o` follows the bank A clock at all times and is never released to high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock, core clock when bypass is off |
| ref_clk | input | 1 | Reference clock, core clock when bypass is on |
| bypass_sel | input | 1 | 1 selects `ref_clk` as the core clock |
| mr_oe | input | 1 | High: reset all dividers and release bank outputs |
| pre_sel | input | 1 | 1 inserts the shared divide-by-two stage |
| sel_a | input | 1 | Bank A ratio select |
| sel_b | input | 1 | Bank B ratio select |
| sel_c | input | 1 | Bank C ratio select |
| qa_o | output | 5 | Bank A clock outputs, tri-state |
| qb_o | output | 4 | Bank B clock outputs, tri-state |
| qc_o | output | 2 | Bank C clock outputs, tri-state |
| fb_o | output | 1 | Feedback clock, copy of bank A |

## Verification
A frame counter that slips or wraps at the wrong count shows up within one 24-cycle frame. Some bank then rises off the common grid, or a high or low phase comes out with the wrong length. A select captured at the wrong moment either changes a waveform in mid-frame, which shows up as a short pulse within a few cycles, or fails to change it at the boundary, which shows up on the first new period. A wrong tri-state enable or a wrong start-up delay can be seen on the very first sample after `mr_oe` moves.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  // Frame length: least common multiple of every total divisor (2,4,6,8,12).
  localparam int unsigned FRAME_LEN = 24;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN);

  // Bank widths and ratio pairs (index 0 = select low, 1 = select high).
  localparam int unsigned BANK_A_W  = 5;
  localparam int unsigned BANK_B_W  = 4;
  localparam int unsigned BANK_C_W  = 2;
  localparam int unsigned A_RATIO_0 = 4;
  localparam int unsigned A_RATIO_1 = 6;
  localparam int unsigned B_RATIO_0 = 4;
  localparam int unsigned B_RATIO_1 = 2;
  localparam int unsigned C_RATIO_0 = 2;
  localparam int unsigned C_RATIO_1 = 4;

  typedef struct packed {
    logic pre;
    logic a;
    logic b;
    logic c;
  } ratio_sel_t;

endpackage

// File: rtl/tcd_rst_sync.sv
module tcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tcd_clk_src.sv
module tcd_clk_src (
  input  logic osc_clk_i,
  input  logic ref_clk_i,
  input  logic bypass_i,
  output logic core_clk_o
);

  // Source is meant to be switched only while the block is held in reset.
  always_comb begin
    core_clk_o = bypass_i ? ref_clk_i : osc_clk_i;
  end

endmodule

// File: rtl/tcd_frame_ctrl.sv
module tcd_frame_ctrl
  import tcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  ratio_sel_t       sel_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             run_o,
  output ratio_sel_t       sel_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  ratio_sel_t       sel_q, sel_d;
  logic             frame_end;

  assign frame_end = (cnt_q == LAST);

  always_comb begin
    run_d = 1'b1;
    cnt_d = cnt_q;
    sel_d = sel_q;
    if (!run_q) begin
      cnt_d = '0;
      sel_d = sel_i;
    end else begin
      cnt_d = frame_end ? '0 : cnt_q + 1'b1;
      if (frame_end) begin
        sel_d = sel_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      sel_q <= sel_d;
    end
  end

  assign phase_o = cnt_q;
  assign run_o   = run_q;
  assign sel_o   = sel_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q < CNT_W'(FRAME_LEN)); // R9

  AST_SEL_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_q && $past(run_q) && ($past(cnt_q) != LAST)) |-> $stable(sel_q)); // R9

endmodule

// File: rtl/tcd_bank_div.sv
module tcd_bank_div
  import tcd_pkg::*;
#(
  parameter int unsigned WIDTH   = 5,
  parameter int unsigned RATIO_0 = 4,
  parameter int unsigned RATIO_1 = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic             pre_i,
  input  logic             sel_i,
  input  logic             oe_i,
  output logic             bank_clk_o,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned MODES = 4;

  logic [MODES-1:0] wave;
  logic [1:0]       mode;
  logic             clk_q, clk_d;

  // One waveform per (pre, sel) pair, each with a constant divisor.
  for (genvar k = 0; k < MODES; k++) begin : g_mode
    localparam int unsigned DIV = (((k & 1) != 0) ? RATIO_1 : RATIO_0) * ((k >> 1) + 1);
    assign wave[k] = ((32'(phase_i) % DIV) < (DIV / 2));
  end

  assign mode = {pre_i, sel_i};

  always_comb begin
    clk_d = run_i ? wave[mode] : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      clk_q <= 1'b0;
    end else begin
      clk_q <= clk_d;
    end
  end

  assign bank_clk_o = clk_q;
  assign q_o        = oe_i ? {WIDTH{clk_q}} : {WIDTH{1'bz}};

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> !clk_q); // R1

endmodule

// File: rtl/tribank_clkdiv.sv
module tribank_clkdiv
  import tcd_pkg::*;
(
  input  logic                osc_clk,
  input  logic                ref_clk,
  input  logic                bypass_sel,
  input  logic                mr_oe,
  input  logic                pre_sel,
  input  logic                sel_a,
  input  logic                sel_b,
  input  logic                sel_c,
  output logic [BANK_A_W-1:0] qa_o,
  output logic [BANK_B_W-1:0] qb_o,
  output logic [BANK_C_W-1:0] qc_o,
  output logic                fb_o
);

  logic             core_clk;
  logic             rst_sync_n;
  logic             run;
  logic             oe;
  logic [CNT_W-1:0] phase;
  ratio_sel_t       sel_in, sel_act;
  logic             clk_a, clk_b, clk_c;

  assign oe     = ~mr_oe;
  assign sel_in = '{pre: pre_sel, a: sel_a, b: sel_b, c: sel_c};

  tcd_clk_src u_src (
    .osc_clk_i  (osc_clk),
    .ref_clk_i  (ref_clk),
    .bypass_i   (bypass_sel),
    .core_clk_o (core_clk)
  );

  tcd_rst_sync #(.STAGES(2)) u_rst (
    .clk_i    (core_clk),
    .arst_n_i (oe),
    .rst_n_o  (rst_sync_n)
  );

  tcd_frame_ctrl u_frame (
    .clk_i   (core_clk),
    .rst_n_i (rst_sync_n),
    .sel_i   (sel_in),
    .phase_o (phase),
    .run_o   (run),
    .sel_o   (sel_act)
  );

  tcd_bank_div #(.WIDTH(BANK_A_W), .RATIO_0(A_RATIO_0), .RATIO_1(A_RATIO_1)) u_bank_a (
    .clk_i      (core_clk),
    .rst_n_i    (rst_sync_n),
    .run_i      (run),
    .phase_i    (phase),
    .pre_i      (sel_act.pre),
    .sel_i      (sel_act.a),
    .oe_i       (oe),
    .bank_clk_o (clk_a),
    .q_o        (qa_o)
  );

  tcd_bank_div #(.WIDTH(BANK_B_W), .RATIO_0(B_RATIO_0), .RATIO_1(B_RATIO_1)) u_bank_b (
    .clk_i      (core_clk),
    .rst_n_i    (rst_sync_n),
    .run_i      (run),
    .phase_i    (phase),
    .pre_i      (sel_act.pre),
    .sel_i      (sel_act.b),
    .oe_i       (oe),
    .bank_clk_o (clk_b),
    .q_o        (qb_o)
  );

  tcd_bank_div #(.WIDTH(BANK_C_W), .RATIO_0(C_RATIO_0), .RATIO_1(C_RATIO_1)) u_bank_c (
    .clk_i      (core_clk),
    .rst_n_i    (rst_sync_n),
    .run_i      (run),
    .phase_i    (phase),
    .pre_i      (sel_act.pre),
    .sel_i      (sel_act.c),
    .oe_i       (oe),
    .bank_clk_o (clk_c),
    .q_o        (qc_o)
  );

  // Feedback copy stays driven regardless of the output enable.
  assign fb_o = clk_a;

  AST_FRAME_ALIGN: assert property (@(posedge core_clk) disable iff (!rst_sync_n)
    (run && (phase == CNT_W'(1))) |-> (clk_a && clk_b && clk_c)); // R8

  AST_CLEAR_IN_RESET: assert property (@(posedge core_clk)
    !rst_sync_n |-> (!clk_a && !clk_b && !clk_c && !run)); // R1

endmodule

// File: tb/tribank_clkdiv_tb_top.sv
module tribank_clkdiv_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 24;

  logic clk_gen = 1'b0;
  logic bypass_sel, mr_oe, pre_sel, sel_a, sel_b, sel_c;
  logic osc_clk, ref_clk;
  wire [4:0] qa_w;
  wire [3:0] qb_w;
  wire [1:0] qc_w;
  wire       fb_w;

  int n_chk = 0;
  int n_err = 0;
  int t;
  logic [3:0] eff;       // {pre, a, b, c} as seen by the waveform
  logic [3:0] pend_sel;
  bit         pending;
  int         chg_t;

  always #(CLK_PERIOD/2) clk_gen = ~clk_gen;
  assign osc_clk = bypass_sel ? 1'b0 : clk_gen;
  assign ref_clk = bypass_sel ? clk_gen : 1'b0;

  // Pull-ups make a released line read as 1 while the internal clock is 0.
  for (genvar i = 0; i < 5; i++) begin : g_pa
    pullup (qa_w[i]);
  end
  for (genvar i = 0; i < 4; i++) begin : g_pb
    pullup (qb_w[i]);
  end
  for (genvar i = 0; i < 2; i++) begin : g_pc
    pullup (qc_w[i]);
  end

  tribank_clkdiv dut_i (
    .osc_clk    (osc_clk),
    .ref_clk    (ref_clk),
    .bypass_sel (bypass_sel),
    .mr_oe      (mr_oe),
    .pre_sel    (pre_sel),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .sel_c      (sel_c),
    .qa_o       (qa_w),
    .qb_o       (qb_w),
    .qc_o       (qc_w),
    .fb_o       (fb_w)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
    end
  endtask

  function automatic int total_div(input int bank, input logic [3:0] s);
    int r;
    case (bank)
      0: r = s[2] ? 6 : 4;   // R3
      1: r = s[1] ? 2 : 4;   // R4
      default: r = s[0] ? 4 : 2; // R5
    endcase
    return s[3] ? 2 * r : r; // R6
  endfunction

  function automatic bit model_level(input int bank, input logic [3:0] s, input int tt);
    int n;
    n = total_div(bank, s);
    return (tt % n) < (n / 2); // R7 R8
  endfunction

  task automatic drive_sel(input logic [3:0] s);
    pre_sel = s[3]; sel_a = s[2]; sel_b = s[1]; sel_c = s[0];
  endtask

  // Reset with the given selects and source, then verify start-up timing.
  task automatic do_reset(input logic [3:0] s, input logic byp);
    @(negedge clk_gen);
    mr_oe = 1'b1;
    #1;
    check(qa_w === 5'h1f, "R1 bank A released", qa_w, 5'h1f);
    check(qb_w === 4'hf,  "R1 bank B released", qb_w, 4'hf);
    check(qc_w === 2'h3,  "R1 bank C released", qc_w, 2'h3);
    check(fb_w === 1'b0,  "R1 R11 fb low", fb_w, 0);
    bypass_sel = byp;
    drive_sel(s);
    repeat (3) @(negedge clk_gen);
    mr_oe = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk_gen);
      if (k < 4) begin
        check(qa_w === 5'h00 && qb_w === 4'h0 && qc_w === 2'h0 && fb_w === 1'b0,
              "R8 R10 quiet before start", {qa_w, qb_w, qc_w}, 0);
      end else begin
        check(qa_w === 5'h1f && qb_w === 4'hf && qc_w === 2'h3 && fb_w === 1'b1,
              "R8 R10 common first rise", {qa_w, qb_w, qc_w}, 11'h7ff);
      end
    end
    t = 0;
    eff = s;
    pending = 0;
  endtask

  task automatic observe(input int ncyc, input string tag);
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk_gen);
      t++;
      if (pending && (t % FRAME == 0) && (t - 1 >= chg_t + 1)) begin
        eff = pend_sel;
        pending = 0;
      end
      begin
        bit ea, eb, ec;
        ea = model_level(0, eff, t);
        eb = model_level(1, eff, t);
        ec = model_level(2, eff, t);
        check(qa_w === {5{ea}}, {tag, " R2 R3 R7 bank A"}, qa_w, {5{ea}});
        check(qb_w === {4{eb}}, {tag, " R2 R4 R7 bank B"}, qb_w, {4{eb}});
        check(qc_w === {2{ec}}, {tag, " R2 R5 R7 bank C"}, qc_w, {2{ec}});
        check(fb_w === ea, {tag, " R11 feedback"}, fb_w, ea);
      end
    end
  endtask

  task automatic test_all_modes();
    for (int s = 0; s < 16; s++) begin
      do_reset(4'(s), 1'b0);
      observe(2 * FRAME, "R6 mode");
    end
  endtask

  task automatic test_sel_change();
    logic [3:0] nxt;
    do_reset(4'b0000, 1'b0);
    observe(30, "R9 before");
    nxt = 4'b1101;
    drive_sel(nxt);
    pend_sel = nxt; pending = 1; chg_t = t;
    observe(3 * FRAME, "R9 after");
    // Change landing right before a frame boundary edge.
    observe(FRAME - 2 - (t % FRAME), "R9 align");
    nxt = 4'b0110;
    drive_sel(nxt);
    pend_sel = nxt; pending = 1; chg_t = t;
    observe(2 * FRAME, "R9 late");
  endtask

  task automatic test_bypass();
    do_reset(4'b0101, 1'b1);
    observe(2 * FRAME, "R10 bypass");
    do_reset(4'b1010, 1'b1);
    observe(2 * FRAME, "R10 bypass pre");
  endtask

  task automatic test_midrun_reset();
    do_reset(4'b1111, 1'b0);
    observe(17, "R1 run");
    @(posedge clk_gen);
    #2;
    mr_oe = 1'b1;
    #1;
    check(qa_w === 5'h1f && qb_w === 4'hf && qc_w === 2'h3, "R1 async release",
          {qa_w, qb_w, qc_w}, 11'h7ff);
    check(fb_w === 1'b0, "R1 async clear fb", fb_w, 0);
    do_reset(4'b0011, 1'b0);
    observe(FRAME, "R1 restart");
  endtask

  initial begin
    mr_oe = 1'b1;
    bypass_sel = 1'b0;
    drive_sel(4'b0000);
    t = 0; eff = '0; pending = 0; chg_t = 0; pend_sel = '0;
    repeat (2) @(negedge clk_gen);
    test_all_modes();
    test_sel_change();
    test_bypass();
    test_midrun_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule